// File: doc/BRIEF.md
# Button-Stepped Eight-Rate LED Blinker

This block blinks a single LED at one of eight rates. A free-running prescaler makes a one-cycle tick every `DIV_TERMINAL` clock cycles. The tick drives an eight-bit binary divider whose bits are the rate taps, and each tap runs at half the frequency of the one below it. A three-bit rate selector picks one tap through an eight-way multiplexer. The chosen tap, gated by an enable switch, is registered onto the LED pin.

The step button passes through a two-flop synchroniser and a hold-time debouncer. Each debounced press advances the rate selector by one. After the slowest setting it returns to the fastest. With a 100 MHz clock and the default terminal count of 1,000,000, the fastest setting blinks at 50 Hz and the slowest at about 0.39 Hz. Simulation sets much shorter counts through the parameters.

Top module: `blink_rate_top`

## Requirements
- R1: The LED is a square wave. At rate setting r (0 to 7), it stays high for 2^r × `DIV_TERMINAL` cycles, and its rising edges are 2^(r+1) × `DIV_TERMINAL` cycles apart. Setting 0 is the fastest and setting 7 is 128 times slower.
- R2: While reset is high and in the cycle after it falls, the LED is low. Reset selects rate setting 0 and clears the divider.
- R3: While `enable_i` is low, the LED stays low from the next clock edge on. When `enable_i` returns high, blinking resumes at the selected rate.
- R4: A press is `step_btn_i` held high for longer than `DEBOUNCE_CYCLES` + 2 cycles and then released. Each such press advances the rate setting by exactly one.
- R5: A press at rate setting 7 wraps the setting to 0.
- R6: A high pulse on `step_btn_i` shorter than `DEBOUNCE_CYCLES` cycles leaves the rate setting unchanged.
- R7: Holding the button high for many debounce windows counts as a single step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Blink enable switch; LED held low when 0 |
| step_btn_i | input | 1 | Raw step push-button, active high |
| led_o | output | 1 | Registered LED drive |

## Verification
A table of press counts is walked from reset: 0, 1, 2 and 3 presses in a row, then single presses that reach setting 7 and wrap to 0, then a double press. After each row the LED's period and high time are measured, so each rate setting is told apart from its neighbours by an exact factor of two. Directed tests follow. A sub-window glitch tells a filtered bounce apart from a real press. A long hold tells one step apart from repeated steps. An enable-off window separates gating from selector state, because the same rate must return afterwards. A mid-run reset shows that the setting really returns to the fastest rate.

// File: rtl/blink_pkg.sv
package blink_pkg;
    localparam int unsigned TAP_COUNT = 8;
    localparam int unsigned SEL_W     = $clog2(TAP_COUNT);
    typedef logic [SEL_W-1:0]     rate_t;
    typedef logic [TAP_COUNT-1:0] taps_t;
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
    parameter int unsigned DIV_TERMINAL = 1_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (DIV_TERMINAL > 2) ? $clog2(DIV_TERMINAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_TERMINAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/blink_divchain.sv
module blink_divchain
    import blink_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  tick_i,
    output taps_t taps_o
);
    taps_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (tick_i) div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) div_q <= '0;
        else       div_q <= div_d;
    end

    // Each output bit is one halving stage of the chain.
    for (genvar k = 0; k < TAP_COUNT; k++) begin : g_tap
        assign taps_o[k] = div_q[k];
    end
endmodule

// File: rtl/blink_debounce.sv
module blink_debounce #(
    parameter int unsigned DEBOUNCE_CYCLES = 1_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_i,
    output logic step_o
);
    localparam int unsigned DW = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [DW-1:0] HOLD_LAST = DW'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [DW-1:0] cnt;
        logic          stable;
        logic          step;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], btn_i};
        st_d.step = 1'b0;
        if (st_q.sync[1] == st_q.stable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == HOLD_LAST) begin
            st_d.cnt    = '0;
            st_d.stable = st_q.sync[1];
            st_d.step   = st_q.sync[1];
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign step_o = st_q.step;
endmodule

// File: rtl/blink_rate_top.sv
module blink_rate_top
    import blink_pkg::*;
#(
    parameter int unsigned DIV_TERMINAL    = 1_000_000,
    parameter int unsigned DEBOUNCE_CYCLES = 1_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic enable_i,
    input  logic step_btn_i,
    output logic led_o
);
    typedef struct packed {
        rate_t rate;
        logic  led;
    } top_t;

    logic  tick;
    logic  step;
    taps_t div_q;
    rate_t rate_q;
    top_t  st_d, st_q;

    blink_prescaler #(.DIV_TERMINAL(DIV_TERMINAL)) u_pre (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(tick)
    );

    blink_divchain u_div (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_i(tick),
        .taps_o(div_q)
    );

    blink_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .btn_i (step_btn_i),
        .step_o(step)
    );

    always_comb begin
        st_d = st_q;
        if (step) st_d.rate = st_q.rate + 1'b1;   // wraps 7 -> 0
        st_d.led = enable_i & div_q[st_q.rate];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign rate_q = st_q.rate;
    assign led_o  = st_q.led;
endmodule

// File: rtl/blink_rate_chk.sv
module blink_rate_chk
    import blink_pkg::*;
(
    input logic  clk_i,
    input logic  rst_i,
    input logic  enable_i,
    input logic  led_o,
    input logic  tick,
    input logic  step,
    input taps_t div_q,
    input rate_t rate_q
);
    p_led_gated_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> !led_o);

    p_reset_state_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (rate_q == '0 && div_q == '0 && !led_o));

    p_step_plus_one_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (rate_q != $past(rate_q)) |-> (rate_q == rate_t'($past(rate_q) + 1'b1)));

    p_step_needs_press_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (rate_q != $past(rate_q)) |-> $past(step));

    p_single_step_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        step |=> !step);

    p_div_on_tick_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (div_q != $past(div_q)) |-> $past(tick));
endmodule

bind blink_rate_top blink_rate_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .enable_i(enable_i),
    .led_o   (led_o),
    .tick    (tick),
    .step    (step),
    .div_q   (div_q),
    .rate_q  (rate_q)
);

// File: tb/tb_blink_rate_top.sv
module tb_blink_rate_top;
    localparam int P   = 4;
    localparam int DEB = 8;
    localparam int NV  = 7;
    localparam int PRESSES [NV] = '{0, 1, 2, 3, 1, 1, 2};
    localparam int EXP_RATE[NV] = '{0, 1, 3, 6, 7, 0, 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic btn = 1'b0;
    logic led;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    blink_rate_top #(.DIV_TERMINAL(P), .DEBOUNCE_CYCLES(DEB)) dut (
        .clk_i(clk), .rst_i(rst), .enable_i(en), .step_btn_i(btn), .led_o(led)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input int hold);
        btn = 1'b1; cyc(hold);
        btn = 1'b0; cyc(DEB + 12);
    endtask

    task automatic wait_rise();
        logic prev;
        prev = led;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (led && !prev) return;
            prev = led;
        end
    endtask

    // Measures the rise-to-rise period and the high time.
    task automatic measure(output int per, output int hi);
        logic prev;
        wait_rise();
        wait_rise();
        per = 0; hi = 0; prev = led;
        for (int i = 0; i < 5000; i++) begin
            if (led) hi++;
            per++;
            @(negedge clk);
            if (led && !prev) break;
            prev = led;
        end
    endtask

    task automatic check_rate(input string req, input int r);
        int per, hi;
        measure(per, hi);
        check(req, per, (2 << r) * P);
        check(req, hi, (1 << r) * P);
    endtask

    initial begin
        cyc(200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        check("R2 led in reset", int'(led), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 led after reset", int'(led), 0);

        // Table walk: R1 rate ladder, R4 stepping, R5 wrap
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < PRESSES[v]; k++) press(DEB + 10);
            check_rate($sformatf("R1/R4/R5 row %0d", v), EXP_RATE[v]);
        end

        // R6: short glitch ignored (rate stays 2)
        btn = 1'b1; cyc(DEB - 4); btn = 1'b0; cyc(DEB + 12);
        check_rate("R6 glitch ignored", 2);

        // R7: long hold gives one step (2 -> 3)
        press(DEB * 20);
        check_rate("R7 hold single step", 3);

        // R3: enable low holds LED low, then blinking resumes at same rate
        en = 1'b0;
        @(negedge clk);
        begin
            int highs = 0;
            for (int i = 0; i < 300; i++) begin
                if (led) highs++;
                @(negedge clk);
            end
            check("R3 led low while disabled", highs, 0);
        end
        en = 1'b1;
        check_rate("R3 resume rate", 3);

        // R2: mid-run reset returns to fastest rate
        rst = 1'b1; cyc(3);
        check("R2 led in mid reset", int'(led), 0);
        rst = 1'b0;
        check_rate("R2 fastest after reset", 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule